// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier Unit

This block gives one group of processing elements a shared hardware barrier. It holds a set of independent barrier blades, six by default. Each blade keeps a participation mask and one status bit per element. A registered combined bit rises when every masked status bit is 1 and falls when every masked status bit is 0. Successive barrier rounds therefore alternate sense, and no clearing step is needed between them.

Every element owns four windows. Each window is a valid flag and a blade index, and it routes that element's status traffic to one blade. All traffic goes through one register port, and each access carries the requesting element's ID. A participant arrives at the barrier in three steps. It reads the combined bit through its window, inverts the bit, and writes the result as its own status bit. It then polls until the combined bit it reads equals the value it wrote. Read data and the error flag appear one clock after the strobe.

The address is `{group[1:0], index[2:0]}`. Group 0 configures the blade named by the index. Group 1 configures the caller's window named by the index. Group 2 gives status access through the caller's window named by the index. Group 3 is unused.

Top module: `hwb_unit`

## Requirements
- R1: Writing group 0 with index b < NUM_BLADES sets blade b's mask to wdata[NUM_ELEMS-1:0] and clears its status bits and combined bit. A read of group 0 returns the status vector at bits [NUM_ELEMS-1:0] and the mask at bits [16 +: NUM_ELEMS]. Blades do not affect one another.
- R2: A group 1 write with index w (0..3) sets window w of the requesting element: valid = wdata[0], blade = wdata[6:4]. A read returns the same layout, or zero if the window is invalid. Each element has its own four windows.
- R3: A group 2 write through a valid window sets only the requesting element's status bit in the target blade, to wdata[0].
- R4: With a non-zero mask, the combined bit becomes 1 one clock after every masked status bit is 1.
- R5: With a non-zero mask, the combined bit becomes 0 one clock after every masked status bit is 0.
- R6: Status bits outside the mask have no effect on the combined bit. A blade whose mask is all zero never changes its combined bit.
- R7: A group 2 read returns the caller's own status bit at bit 0, the combined bit at bit 8 and the mask at bits [16 +: NUM_ELEMS].
- R8: Read data and the error flag are registered and are valid in the cycle after the strobe. A status read issued in the cycle right after the completing status write returns the old combined bit. The read after that returns the new value.
- R9: A group 2 access through a window whose valid flag is clear has no effect on a write and reads as zero. It sets rsp_err in the following cycle.
- R10: Each of the following is ignored, reads as zero and sets rsp_err: a blade index ≥ NUM_BLADES in group 0, a window index > 3, an element ID ≥ NUM_ELEMS, group 3, and a window write that is valid but names a blade ≥ NUM_BLADES (the old window entry is kept).
- R11: Reset clears all masks, status bits, combined bits, window valid flags and response outputs.
- R12: Two consecutive barrier rounds complete using opposite sense, with no re-initialisation between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_addr | input | 5 | Group (bits 4:3) and index (bits 2:0) |
| acc_elem | input | 4 | ID of the requesting element |
| acc_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the strobe, zero otherwise |
| rsp_err | output | 1 | Error flag for the access of the previous cycle |

## Verification
A wrong mask, status bit or combined bit inside a blade shows up at the ports on the next group 0 or group 2 read of that blade. A status bit written to the wrong element or the wrong blade changes the status vector that group 0 returns. A combined bit that updates at the wrong time shows as a mismatch within one or two reads after the completing write. A corrupted window entry shows either on its group 1 read-back, or as a false error or a status read that hits the wrong blade on the next group 2 access.

// File: rtl/hwb_pkg.sv
package hwb_pkg;

  typedef enum logic [1:0] {
    GRP_BLADE = 2'd0,
    GRP_WIN   = 2'd1,
    GRP_STAT  = 2'd2,
    GRP_NONE  = 2'd3
  } grp_e;

  localparam int WINDOWS       = 4;
  localparam int WIN_W         = 2;
  localparam int OWN_BIT       = 0;
  localparam int BUSY_BIT      = 8;
  localparam int MASK_LSB      = 16;
  localparam int WIN_BLADE_LSB = 4;

endpackage

// File: rtl/hwb_blade.sv
module hwb_blade #(
  parameter int NUM_ELEMS = 13,
  parameter int ELEM_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init_we,
  input  logic [NUM_ELEMS-1:0] init_mask,
  input  logic                 st_we,
  input  logic [ELEM_W-1:0]    st_elem,
  input  logic                 st_val,
  output logic [NUM_ELEMS-1:0] mask_q,
  output logic [NUM_ELEMS-1:0] stat_q,
  output logic                 busy_q
);

  logic [NUM_ELEMS-1:0] masked;
  logic                 live;
  logic                 all_one;
  logic                 all_zero;

  assign masked   = stat_q & mask_q;
  assign live     = |mask_q;
  assign all_one  = live && (masked == mask_q);
  assign all_zero = live && (masked == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      stat_q <= '0;
      busy_q <= 1'b0;
    end else if (init_we) begin
      mask_q <= init_mask;
      stat_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (st_we) begin
        for (int i = 0; i < NUM_ELEMS; i++) begin
          if (ELEM_W'(i) == st_elem) stat_q[i] <= st_val;
        end
      end
      if (all_one)       busy_q <= 1'b1;
      else if (all_zero) busy_q <= 1'b0;
    end
  end

endmodule

// File: rtl/hwb_win_table.sv
module hwb_win_table #(
  parameter int TA_W   = 6,
  parameter int BIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [TA_W-1:0]   addr,
  input  logic              wvalid,
  input  logic [BIDX_W-1:0] wblade,
  output logic              rvalid,
  output logic [BIDX_W-1:0] rblade
);

  localparam int DEPTH = 1 << TA_W;

  logic [DEPTH-1:0]  valid_q;
  logic [BIDX_W-1:0] blade_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (we) valid_q[addr] <= wvalid;
  end

  always_ff @(posedge clk) begin
    if (we) blade_mem[addr] <= wblade;
  end

  assign rvalid = valid_q[addr];
  assign rblade = rvalid ? blade_mem[addr] : '0;

endmodule

// File: rtl/hwb_unit.sv
module hwb_unit
  import hwb_pkg::*;
#(
  parameter int NUM_BLADES = 6,
  parameter int NUM_ELEMS  = 13,
  parameter int DATA_W     = 32,
  localparam int BIDX_W    = (NUM_BLADES > 1) ? $clog2(NUM_BLADES) : 1,
  localparam int ELEM_W    = $clog2(NUM_ELEMS + 1),
  localparam int IDX_W     = (BIDX_W > 3) ? BIDX_W : 3,
  localparam int ADDR_W    = 2 + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ELEM_W-1:0] acc_elem,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);

  localparam int TA_W = ELEM_W + WIN_W;

  grp_e                              grp;
  logic [IDX_W-1:0]                  idx;
  logic                              elem_ok;
  logic                              win_ok;
  logic                              blade_ok;
  logic [BIDX_W-1:0]                 new_blade;
  logic                              new_valid;
  logic                              new_ok;
  logic                              win_valid;
  logic [BIDX_W-1:0]                 win_blade;
  logic                              tbl_we;
  logic                              ok;
  logic [DATA_W-1:0]                 rd_word;
  logic [NUM_BLADES-1:0]             init_we;
  logic [NUM_BLADES-1:0]             st_we;
  logic [NUM_BLADES-1:0][NUM_ELEMS-1:0] blade_mask;
  logic [NUM_BLADES-1:0][NUM_ELEMS-1:0] blade_stat;
  logic [NUM_BLADES-1:0]             blade_busy;
  logic [NUM_ELEMS-1:0]              sel_mask;
  logic [NUM_ELEMS-1:0]              sel_stat;
  logic                              sel_busy;

  assign grp       = grp_e'(acc_addr[ADDR_W-1 -: 2]);
  assign idx       = acc_addr[IDX_W-1:0];
  assign elem_ok   = acc_elem < ELEM_W'(NUM_ELEMS);
  assign win_ok    = idx[IDX_W-1:WIN_W] == '0;
  assign blade_ok  = {1'b0, idx} < (IDX_W + 1)'(NUM_BLADES);
  assign new_valid = acc_wdata[0];
  assign new_blade = acc_wdata[WIN_BLADE_LSB +: BIDX_W];
  assign new_ok    = !new_valid || ({1'b0, new_blade} < (BIDX_W + 1)'(NUM_BLADES));

  hwb_win_table #(
    .TA_W  (TA_W),
    .BIDX_W(BIDX_W)
  ) u_win (
    .clk   (clk),
    .rst   (rst),
    .we    (tbl_we),
    .addr  ({acc_elem, idx[WIN_W-1:0]}),
    .wvalid(new_valid),
    .wblade(new_blade),
    .rvalid(win_valid),
    .rblade(win_blade)
  );

  for (genvar b = 0; b < NUM_BLADES; b++) begin : g_blade
    hwb_blade #(
      .NUM_ELEMS(NUM_ELEMS),
      .ELEM_W   (ELEM_W)
    ) u_blade (
      .clk      (clk),
      .rst      (rst),
      .init_we  (init_we[b]),
      .init_mask(acc_wdata[NUM_ELEMS-1:0]),
      .st_we    (st_we[b]),
      .st_elem  (acc_elem),
      .st_val   (acc_wdata[0]),
      .mask_q   (blade_mask[b]),
      .stat_q   (blade_stat[b]),
      .busy_q   (blade_busy[b])
    );
  end

  assign sel_mask = blade_mask[win_blade];
  assign sel_stat = blade_stat[win_blade];
  assign sel_busy = blade_busy[win_blade];

  always_comb begin
    ok      = 1'b0;
    tbl_we  = 1'b0;
    init_we = '0;
    st_we   = '0;
    rd_word = '0;
    case (grp)
      GRP_BLADE: begin
        ok = elem_ok && blade_ok;
        if (ok) begin
          init_we[idx] = acc_wr;
          rd_word[NUM_ELEMS-1:0]          = blade_stat[idx];
          rd_word[MASK_LSB +: NUM_ELEMS]  = blade_mask[idx];
        end
      end
      GRP_WIN: begin
        ok     = elem_ok && win_ok && (!acc_wr || new_ok);
        tbl_we = acc_wr && ok;
        rd_word[0]                          = win_valid;
        rd_word[WIN_BLADE_LSB +: BIDX_W]    = win_blade;
      end
      GRP_STAT: begin
        ok = elem_ok && win_ok && win_valid;
        if (ok) begin
          st_we[win_blade]               = acc_wr;
          rd_word[OWN_BIT]               = sel_stat[acc_elem];
          rd_word[BUSY_BIT]              = sel_busy;
          rd_word[MASK_LSB +: NUM_ELEMS] = sel_mask;
        end
      end
      default: ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_err   <= (acc_rd || acc_wr) && !ok;
      rsp_rdata <= (acc_rd && ok) ? rd_word : '0;
    end
  end

endmodule

// File: rtl/hwb_unit_chk.sv
module hwb_unit_chk #(
  parameter int NUM_BLADES = 6,
  parameter int NUM_ELEMS  = 13,
  parameter int DATA_W     = 32
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [NUM_BLADES-1:0][NUM_ELEMS-1:0] blade_mask,
  input logic [NUM_BLADES-1:0][NUM_ELEMS-1:0] blade_stat,
  input logic [NUM_BLADES-1:0]                blade_busy,
  input logic [NUM_BLADES-1:0]                init_we,
  input logic [DATA_W-1:0]                    rsp_rdata,
  input logic                                 rsp_err
);

  for (genvar b = 0; b < NUM_BLADES; b++) begin : g_chk
    p_init_clears_r1: assert property (@(posedge clk) disable iff (rst)
      init_we[b] |=> (blade_stat[b] == '0) && !blade_busy[b]);

    p_one_bit_r3: assert property (@(posedge clk) disable iff (rst)
      !init_we[b] |=> $countones(blade_stat[b] ^ $past(blade_stat[b])) <= 1);

    p_busy_set_r4: assert property (@(posedge clk) disable iff (rst)
      (!init_we[b] && (blade_mask[b] != '0) &&
       ((blade_stat[b] & blade_mask[b]) == blade_mask[b])) |=> blade_busy[b]);

    p_busy_clr_r5: assert property (@(posedge clk) disable iff (rst)
      (!init_we[b] && (blade_mask[b] != '0) &&
       ((blade_stat[b] & blade_mask[b]) == '0)) |=> !blade_busy[b]);

    p_zero_mask_r6: assert property (@(posedge clk) disable iff (rst)
      (!init_we[b] && (blade_mask[b] == '0)) |=> $stable(blade_busy[b]));
  end

  p_err_zero_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));

endmodule

bind hwb_unit hwb_unit_chk #(
  .NUM_BLADES(NUM_BLADES),
  .NUM_ELEMS (NUM_ELEMS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .blade_mask(blade_mask),
  .blade_stat(blade_stat),
  .blade_busy(blade_busy),
  .init_we   (init_we),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/hwb_unit_test.sv
module hwb_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;
  localparam int EW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          a_rd = 1'b0;
  logic          a_wr = 1'b0;
  logic [AW-1:0] a_addr = '0;
  logic [EW-1:0] a_elem = '0;
  logic [DW-1:0] a_wd = '0;
  logic [DW-1:0] r_data;
  logic          r_err;

  int vec  = 0;
  int bad  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hwb_unit uut (
    .clk      (clk),
    .rst      (rst),
    .acc_rd   (a_rd),
    .acc_wr   (a_wr),
    .acc_addr (a_addr),
    .acc_elem (a_elem),
    .acc_wdata(a_wd),
    .rsp_rdata(r_data),
    .rsp_err  (r_err)
  );

  function automatic int blade_a(int b); return b;      endfunction
  function automatic int win_a(int w);   return 8 + w;  endfunction
  function automatic int stat_a(int w);  return 16 + w; endfunction

  // one access per call; caller sits at a falling edge
  task automatic acc(input logic rd, input logic wr, input int elem, input int addr,
                     input logic [DW-1:0] wd, input logic [DW-1:0] exp_d,
                     input logic exp_e, input string tag);
    a_rd = rd; a_wr = wr; a_elem = EW'(elem); a_addr = AW'(addr); a_wd = wd;
    @(negedge clk);
    a_rd = 1'b0; a_wr = 1'b0;
    vec++;
    if (r_data !== exp_d || r_err !== exp_e) begin
      bad++;
      $display("FAIL %s: got data=%h err=%b, expected data=%h err=%b",
               tag, r_data, r_err, exp_d, exp_e);
    end
  endtask

  task automatic wr(input int elem, input int addr, input logic [DW-1:0] wd,
                    input logic exp_e, input string tag);
    acc(1'b0, 1'b1, elem, addr, wd, '0, exp_e, tag);
  endtask

  task automatic rd(input int elem, input int addr, input logic [DW-1:0] exp_d,
                    input logic exp_e, input string tag);
    acc(1'b1, 1'b0, elem, addr, '0, exp_d, exp_e, tag);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd(0, blade_a(0), 32'h0, 1'b0, "R11 blade 0 after reset");
    rd(0, win_a(0),   32'h0, 1'b0, "R11 window after reset");
    rd(0, stat_a(0),  32'h0, 1'b1, "R11 status via cleared window");
  endtask

  task automatic t_setup();
    wr(0, blade_a(2), 32'h7,  1'b0, "R1 init blade 2");
    wr(0, blade_a(3), 32'h18, 1'b0, "R1 init blade 3");
    rd(0, blade_a(2), 32'h0007_0000, 1'b0, "R1 blade 2 mask readback");
    wr(0, win_a(1), 32'h21, 1'b0, "R2 elem0 w1");
    wr(1, win_a(0), 32'h21, 1'b0, "R2 elem1 w0");
    wr(2, win_a(3), 32'h21, 1'b0, "R2 elem2 w3");
    wr(3, win_a(0), 32'h31, 1'b0, "R2 elem3 w0");
    wr(4, win_a(0), 32'h31, 1'b0, "R2 elem4 w0");
    wr(5, win_a(0), 32'h31, 1'b0, "R2 elem5 w0");
    rd(0, win_a(1), 32'h21, 1'b0, "R2 elem0 w1 readback");
    rd(1, win_a(1), 32'h0,  1'b0, "R2 elem1 w1 untouched");
    rd(0, stat_a(1), 32'h0007_0000, 1'b0, "R7 status layout before round");
  endtask

  task automatic t_round1();
    wr(0, stat_a(1), 32'h1, 1'b0, "R3 elem0 arrives");
    rd(0, blade_a(2), 32'h0007_0001, 1'b0, "R3 only elem0 bit set");
    wr(1, stat_a(0), 32'h1, 1'b0, "R3 elem1 arrives");
    idle();
    rd(0, stat_a(1), 32'h0007_0001, 1'b0, "R4 not complete with elem2 pending");
    wr(2, stat_a(3), 32'h1, 1'b0, "R3 elem2 arrives");
    rd(0, stat_a(1), 32'h0007_0001, 1'b0, "R8 old combined bit right after");
    rd(0, stat_a(1), 32'h0007_0101, 1'b0, "R4 combined bit set");
    rd(2, stat_a(3), 32'h0007_0101, 1'b0, "R7 elem2 sees pass");
  endtask

  task automatic t_masking();
    wr(5, stat_a(0), 32'h1, 1'b0, "R6 unmasked elem5 writes");
    wr(3, stat_a(0), 32'h1, 1'b0, "R6 elem3 writes");
    idle();
    rd(0, blade_a(3), 32'h0018_0028, 1'b0, "R1 blade 3 status vector");
    rd(3, stat_a(0), 32'h0018_0001, 1'b0, "R6 unmasked bit does not complete");
    wr(0, blade_a(4), 32'h0,  1'b0, "R6 init blade 4 empty mask");
    wr(6, win_a(0),   32'h41, 1'b0, "R2 elem6 w0");
    wr(6, stat_a(0),  32'h1,  1'b0, "R6 elem6 writes");
    idle(); idle();
    rd(6, stat_a(0), 32'h0000_0001, 1'b0, "R6 zero mask keeps busy 0");
  endtask

  task automatic t_round2();
    wr(0, stat_a(1), 32'h0, 1'b0, "R12 elem0 round 2");
    wr(1, stat_a(0), 32'h0, 1'b0, "R12 elem1 round 2");
    idle();
    rd(2, stat_a(3), 32'h0007_0101, 1'b0, "R5 busy held while elem2 pending");
    wr(2, stat_a(3), 32'h0, 1'b0, "R12 elem2 round 2");
    idle();
    rd(0, stat_a(1), 32'h0007_0000, 1'b0, "R5 busy cleared, round 2 passed");
    rd(0, blade_a(2), 32'h0007_0000, 1'b0, "R12 all status back to 0");
  endtask

  task automatic t_errors();
    wr(0, stat_a(2), 32'h1, 1'b1, "R9 write via invalid window");
    rd(0, stat_a(2), 32'h0, 1'b1, "R9 read via invalid window");
    rd(0, blade_a(2), 32'h0007_0000, 1'b0, "R9 blade unchanged");
    wr(0, blade_a(6), 32'h1, 1'b1, "R10 blade index 6 write");
    rd(0, blade_a(6), 32'h0, 1'b1, "R10 blade index 6 read");
    rd(0, 12, 32'h0, 1'b1, "R10 window index 4");
    rd(13, blade_a(0), 32'h0, 1'b1, "R10 element 13");
    rd(0, 24, 32'h0, 1'b1, "R10 group 3");
    wr(0, win_a(1), 32'h71, 1'b1, "R10 window to blade 7");
    rd(0, win_a(1), 32'h21, 1'b0, "R10 old window entry kept");
    wr(1, win_a(0), 32'h0, 1'b0, "R2 elem1 w0 invalidated");
    rd(1, stat_a(0), 32'h0, 1'b1, "R9 status via invalidated window");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_setup();
    t_round1();
    t_masking();
    t_round2();
    t_errors();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

endmodule